// File: doc/BRIEF.md
# Dithered DDS Phase Generator

This block is the phase front end of a direct digital synthesizer. It keeps an ACC_W-bit phase accumulator in which the full binary range stands for one turn of 2π. On each enabled clock it adds a phase step to the accumulator. It then adds a phase shift and, if dither is enabled, a small pseudo-random term. The top OUT_W bits of the result go out as the phase word that a later sine/cosine table reads.

Each of the step and the shift is chosen at build time. It is either a fixed parameter or a register that is written through a shared data port. The shift can also be left out. The accumulator can present its sum in the same cycle (zero latency) or from its register (one cycle). The dither comes from a Galois LFSR. Only the bits below the output word receive dither, so it spreads the truncation error without moving the phase by a whole output step. ACC_W must lie between 3 and 32, DIN_W must not exceed ACC_W, and OUT_W must be less than ACC_W.

Top module: `dds_phase_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator to zero and loads the LFSR with LFSR_SEED. It also returns the loaded step and shift registers to INC_CONST and OFS_CONST. Reset wins over `ce`.
- R2: On every edge with `ce` high and `rst` low, the accumulator takes accumulator + step, modulo 2^ACC_W, with no saturation.
- R3: With `ce` low, the accumulator and the LFSR hold their values, so the output word does not change unless a load alters the step or the shift.
- R4: In loaded step mode, an edge with `inc_wr` high stores `load_data`, zero-extended from DIN_W to ACC_W. The new step is first used by the accumulation at the following enabled edge.
- R5: The shift source is constant (OFS_CONST), loaded (stored from `load_data` on `ofs_wr`, taking effect in the cycle after the write edge), or absent (zero). The shift is added modulo 2^ACC_W.
- R6: With ACC_LAT = 1 the phase sum uses the accumulator register. With ACC_LAT = 0 it uses accumulator + step computed combinationally, so the result of the next accumulation is already visible.
- R7: With DITHER_EN = 1, the LFSR advances on each enabled edge by a right shift. When the bit shifted out is 1, the new state is XORed with LFSR_TAPS (default 16'hB400, seed 16'h0001). The low ACC_W−OUT_W bits of the current state are added after the shift, modulo 2^ACC_W. With DITHER_EN = 0 nothing is added.
- R8: `phase_out` equals bits [ACC_W−1 : ACC_W−OUT_W] of (phase sum + shift + dither) mod 2^ACC_W.
- R9: In constant step mode the step is always INC_CONST, and `inc_wr` and `load_data` have no effect on the output. In absent shift mode, `ofs_wr` has no effect on the output.
- R10: Asserting `inc_wr` and `ofs_wr` on the same edge stores `load_data` into both loaded registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for the accumulator and the LFSR |
| inc_wr | input | 1 | Store `load_data` as the phase step |
| ofs_wr | input | 1 | Store `load_data` as the phase shift |
| load_data | input | DIN_W | Value for step or shift loads |
| phase_out | output | OUT_W | Truncated phase word |

## Verification
The assertions assume that reset is applied at the first clock edge, so the accumulator, the LFSR and the loaded registers start from known values. They also assume that `load_data` is never wider than the accumulator. The stimulus holds `rst` from time zero and keeps DIN_W equal to ACC_W. It changes every input only on the falling clock edge, so each rising edge sees stable step, shift and enable values. Write pulses last one cycle and are sometimes combined with `ce` low, which exercises the case where a load arrives while the accumulator holds.

// File: rtl/dds_phase_pkg.sv
package dds_phase_pkg;

    // Build-time origin of the phase step or the phase shift
    typedef enum logic [1:0] {
        SRC_CONST  = 2'd0,
        SRC_LOADED = 2'd1,
        SRC_NONE   = 2'd2
    } src_mode_e;

endpackage

// File: rtl/dds_word_src.sv
module dds_word_src
    import dds_phase_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter int unsigned DIN_W     = 8,
    parameter src_mode_e   MODE      = SRC_LOADED,
    parameter logic [W-1:0] CONST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [DIN_W-1:0] din,
    output logic [W-1:0]     val
);

    generate
        if (MODE == SRC_LOADED) begin : g_loaded
            logic [W-1:0] word_q;
            // R4 R5 R10: store on write, back to the constant on reset
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= CONST_VAL;
                end else if (wr) begin
                    word_q <= W'(din);
                end
            end
            assign val = word_q;
        end else if (MODE == SRC_CONST) begin : g_const
            logic unused_const;
            assign unused_const = ^{clk, rst, wr, din};
            assign val = CONST_VAL;     // R9
        end else begin : g_none
            logic unused_none;
            assign unused_none = ^{clk, rst, wr, din};
            assign val = '0;
        end
    endgenerate

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int unsigned W   = 8,
    parameter int unsigned LAT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] step,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] phase
);

    logic [W-1:0] acc_nxt;

    // R2: modulo 2^W wrap, no saturation
    assign acc_nxt = acc_q + step;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ce) begin
            acc_q <= acc_nxt;
        end
    end

    // R6: latency selection
    generate
        if (LAT == 0) begin : g_lat0
            assign phase = acc_nxt;
        end else begin : g_lat1
            assign phase = acc_q;
        end
    endgenerate

endmodule

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr #(
    parameter int unsigned   LW   = 16,
    parameter int unsigned   DW   = 2,
    parameter int unsigned   EN   = 1,
    parameter logic [LW-1:0] TAPS = 16'hB400,
    parameter logic [LW-1:0] SEED = 16'h0001
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    output logic [LW-1:0] state_q,
    output logic [DW-1:0] dither
);

    logic [LW-1:0] state_nxt;

    // R7: Galois right shift, feedback from the bit shifted out
    assign state_nxt = {1'b0, state_q[LW-1:1]} ^ (state_q[0] ? TAPS : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (ce) begin
            state_q <= state_nxt;
        end
    end

    generate
        if (EN != 0) begin : g_on
            assign dither = state_q[DW-1:0];
        end else begin : g_off
            assign dither = '0;
        end
    endgenerate

endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
    import dds_phase_pkg::*;
#(
    parameter int unsigned      ACC_W     = 8,
    parameter int unsigned      OUT_W     = 6,
    parameter int unsigned      DIN_W     = 8,
    parameter src_mode_e        INC_SRC   = SRC_LOADED,
    parameter src_mode_e        OFS_SRC   = SRC_LOADED,
    parameter logic [ACC_W-1:0] INC_CONST = ACC_W'(3),
    parameter logic [ACC_W-1:0] OFS_CONST = '0,
    parameter int unsigned      ACC_LAT   = 1,
    parameter int unsigned      DITHER_EN = 1,
    parameter int unsigned      LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'h0001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             inc_wr,
    input  logic             ofs_wr,
    input  logic [DIN_W-1:0] load_data,
    output logic [OUT_W-1:0] phase_out
);

    localparam int unsigned DITH_W = ACC_W - OUT_W;

    logic [ACC_W-1:0]  inc_val;
    logic [ACC_W-1:0]  ofs_val;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_phase;
    logic [LFSR_W-1:0] lfsr_q;
    logic [DITH_W-1:0] dither;
    logic [ACC_W-1:0]  phase_mix;

    dds_word_src #(
        .W(ACC_W), .DIN_W(DIN_W), .MODE(INC_SRC), .CONST_VAL(INC_CONST)
    ) u_inc_src (
        .clk(clk), .rst(rst), .wr(inc_wr), .din(load_data), .val(inc_val)
    );

    dds_word_src #(
        .W(ACC_W), .DIN_W(DIN_W), .MODE(OFS_SRC), .CONST_VAL(OFS_CONST)
    ) u_ofs_src (
        .clk(clk), .rst(rst), .wr(ofs_wr), .din(load_data), .val(ofs_val)
    );

    dds_phase_acc #(
        .W(ACC_W), .LAT(ACC_LAT)
    ) u_acc (
        .clk(clk), .rst(rst), .ce(ce), .step(inc_val),
        .acc_q(acc_q), .phase(acc_phase)
    );

    dds_dither_lfsr #(
        .LW(LFSR_W), .DW(DITH_W), .EN(DITHER_EN),
        .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
    ) u_dither (
        .clk(clk), .rst(rst), .ce(ce), .state_q(lfsr_q), .dither(dither)
    );

    // R5 R7 R8: shift and dither wrap modulo 2^ACC_W, keep the top bits
    assign phase_mix = acc_phase + ofs_val + ACC_W'(dither);
    assign phase_out = phase_mix[ACC_W-1 -: OUT_W];

endmodule

// File: rtl/dds_phase_chk.sv
module dds_phase_chk
    import dds_phase_pkg::*;
#(
    parameter int unsigned       ACC_W     = 8,
    parameter int unsigned       DIN_W     = 8,
    parameter int unsigned       LFSR_W    = 16,
    parameter src_mode_e         INC_SRC   = SRC_LOADED,
    parameter logic [ACC_W-1:0]  INC_CONST = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              inc_wr,
    input logic [DIN_W-1:0]  load_data,
    input logic [ACC_W-1:0]  acc_q,
    input logic [ACC_W-1:0]  inc_val,
    input logic [LFSR_W-1:0] lfsr_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (acc_q == '0));

    p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
        ce |=> (acc_q == ACC_W'($past(acc_q) + $past(inc_val))));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(acc_q) && $stable(lfsr_q)));

    p_lfsr_live_r7: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    generate
        if (INC_SRC == SRC_LOADED) begin : g_ld
            p_inc_load_r4: assert property (@(posedge clk) disable iff (rst)
                inc_wr |=> (inc_val == ACC_W'($past(load_data))));
        end else begin : g_fx
            logic unused_fx;
            assign unused_fx = ^{inc_wr, load_data};
            p_inc_fixed_r9: assert property (@(posedge clk) disable iff (rst)
                inc_val == INC_CONST);
        end
    endgenerate

endmodule

bind dds_phase_gen dds_phase_chk #(
    .ACC_W(ACC_W), .DIN_W(DIN_W), .LFSR_W(LFSR_W),
    .INC_SRC(INC_SRC), .INC_CONST(INC_CONST)
) u_chk (
    .clk(clk), .rst(rst), .ce(ce), .inc_wr(inc_wr), .load_data(load_data),
    .acc_q(acc_q), .inc_val(inc_val), .lfsr_q(lfsr_q)
);

// File: tb/dds_phase_gen_test.sv
`timescale 1ns/1ps
module dds_phase_gen_test;
    import dds_phase_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic       inc_wr = 1'b0;
    logic       ofs_wr = 1'b0;
    logic [7:0] load_data = '0;
    logic [5:0] out_a;
    logic [5:0] out_b;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    // A: loaded step and shift, latency 1, dither on
    dds_phase_gen #(
        .ACC_W(8), .OUT_W(6), .DIN_W(8),
        .INC_SRC(SRC_LOADED), .OFS_SRC(SRC_LOADED),
        .INC_CONST(8'd5), .OFS_CONST(8'd17),
        .ACC_LAT(1), .DITHER_EN(1)
    ) uut (
        .clk(clk), .rst(rst), .ce(ce), .inc_wr(inc_wr), .ofs_wr(ofs_wr),
        .load_data(load_data), .phase_out(out_a)
    );

    // B: constant step, no shift, latency 0, no dither
    dds_phase_gen #(
        .ACC_W(8), .OUT_W(6), .DIN_W(8),
        .INC_SRC(SRC_CONST), .OFS_SRC(SRC_NONE),
        .INC_CONST(8'd37), .OFS_CONST(8'd0),
        .ACC_LAT(0), .DITHER_EN(0)
    ) uut_b (
        .clk(clk), .rst(rst), .ce(ce), .inc_wr(inc_wr), .ofs_wr(ofs_wr),
        .load_data(load_data), .phase_out(out_b)
    );

    // Arithmetic reference model
    int acc_a, inc_a, ofs_a, acc_b;
    int lf;

    function automatic int lfsr_step(input int s);
        int n;
        n = s >> 1;
        if ((s & 1) != 0) n = n ^ 'hB400;
        return n & 'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            acc_a = 0; inc_a = 5; ofs_a = 17; lf = 1; acc_b = 0;
        end else begin
            if (ce) begin
                acc_a = (acc_a + inc_a) & 255;
                acc_b = (acc_b + 37) & 255;
                lf = lfsr_step(lf);
            end
            if (inc_wr) inc_a = int'(load_data);
            if (ofs_wr) ofs_a = int'(load_data);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock, then compare both instances at the falling edge
    task automatic cyc(input string tag);
        int ea, eb;
        @(posedge clk);
        @(negedge clk);
        ea = ((acc_a + ofs_a + (lf & 3)) & 255) >> 2;   // R6 R7 R8
        eb = ((acc_b + 37) & 255) >> 2;                 // R6 R9
        chk({tag, " uut R7 R8"}, int'(out_a), ea);
        chk({tag, " uut_b R6 R9"}, int'(out_b), eb);
    endtask

    initial begin
        #(8ns * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state, even with ce high
        ce = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R1 reset");
        @(negedge clk);
        rst = 1'b0;

        // R2: free running with wrap
        for (int i = 0; i < 300; i++) cyc("R2 wrap");

        // R4: every step value, with inc_wr also hitting uut_b (R9)
        for (int v = 0; v < 256; v++) begin
            load_data = 8'(v); inc_wr = 1'b1;
            cyc("R4 step load");
            inc_wr = 1'b0; load_data = 8'(255 - v);
            for (int k = 0; k < 3; k++) cyc("R4 step run");
        end

        // R5: every shift value, also ignored by uut_b (R9)
        for (int v = 0; v < 256; v++) begin
            load_data = 8'(v); ofs_wr = 1'b1;
            cyc("R5 shift load");
            ofs_wr = 1'b0;
            cyc("R5 shift run");
        end

        // R3: enable pattern with loads while held
        for (int i = 0; i < 240; i++) begin
            ce = (i % 3) != 0;
            inc_wr = (i % 7) == 0;
            ofs_wr = (i % 11) == 0;
            load_data = 8'(i * 29 + 3);
            cyc("R3 enable hold");
        end
        inc_wr = 1'b0; ofs_wr = 1'b0; ce = 1'b1;

        // R10: simultaneous writes
        for (int i = 0; i < 40; i++) begin
            load_data = 8'(i * 53 + 7);
            inc_wr = 1'b1; ofs_wr = 1'b1;
            cyc("R10 dual load");
            inc_wr = 1'b0; ofs_wr = 1'b0;
            cyc("R10 dual run");
            cyc("R10 dual run");
        end

        // R1: reset mid-run with ce low restores loaded defaults
        ce = 1'b0; rst = 1'b1;
        cyc("R1 mid reset");
        rst = 1'b0; ce = 1'b1;
        for (int i = 0; i < 20; i++) cyc("R1 after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule